// File: doc/BRIEF.md
# Soft Reset and Clock-Gate Controller

This block is the root control register of a group of peripheral channels. Two bits carry the protocol: a soft-reset request and a clock-gate flag. When software raises the soft-reset request, every downstream channel sees its synchronous reset asserted. A fixed number of cycles later, the controller raises the clock-gate flag itself. Software polls for that flag as a handshake that the reset has taken effect, instead of assuming the reset happens at once.

To bring the channels back, software lowers the soft-reset request and then clears the clock-gate flag. It polls until each bit reads back zero. Before it starts a new reset, software first clears both bits, so that the hardware's later raising of the gate flag can be seen. The gate itself is modelled only as an enable output that goes low while the flag is set.

The register sits behind a 32-bit write port with four word offsets:
- a plain load,
- a bit-set alias,
- a bit-clear alias,
- a bit-toggle alias.

Reads return the register at any offset.

Top module: `softgate_top`

## Requirements
- R1: After power-on reset both the soft-reset bit and the clock-gate bit are 1. The register reads 0xC000_0000, `clkEn` is 0 and every `chanRst` line is 1.
- R2: The soft-reset bit sits at bit 31 and the clock-gate bit at bit 30. All other bits read 0. `busRdata` shows the register combinationally for every offset in the window.
- R3: A write to offset 0x0 loads both bits from bits 31 and 30 of `busWdata`. The new value is visible after the clock edge that takes the write.
- R4: A write to offset 0x4 sets every register bit whose `busWdata` bit is 1 and leaves the others unchanged.
- R5: A write to offset 0x8 clears every register bit whose `busWdata` bit is 1 and leaves the others unchanged.
- R6: A write to offset 0xC inverts every register bit whose `busWdata` bit is 1 and leaves the others unchanged.
- R7: The soft-reset bit may go from 0 to 1 at clock edge t. If it is still 1 at that point, the hardware sets the clock-gate bit at edge t+GATE_DELAY and not before.
- R8: The hardware sets the clock-gate bit only once per rising of the soft-reset bit. A software clear of the gate flag while soft reset stays high holds, and so does a repeated write of soft reset = 1 while it is already set.
- R9: If the soft-reset bit falls before GATE_DELAY edges have passed, the gate flag is not set. The next rising restarts the full delay.
- R10: The hardware may set the gate flag in the same cycle as a software clear or toggle of that bit. When both happen in one cycle, the bit ends at 1.
- R11: Every `chanRst` line equals the soft-reset bit, and `clkEn` is the inverse of the clock-gate bit, in every cycle.
- R12: While `busWrite` is 0, changes on `busAddr` and `busWdata` leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| busWrite | input | 1 | Write strobe for one cycle |
| busAddr | input | ADDR_W | Byte offset; bits [3:2] select load, set, clear or toggle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Register contents |
| chanRst | output | NUM_CH | Synchronous reset to each channel |
| clkEn | output | 1 | Clock enable standing in for the gate cell |

## Verification
The hardware setting of the gate flag can land on the same edge as a software clear or toggle of that flag. The bench provokes this by timing an alias write so that the clock edge taking it is exactly GATE_DELAY edges after the soft-reset rising. It then judges the result by reading a 1 back from the gate bit. The bench also sweeps every pair of starting state and write mask through all four offsets. The expected value is worked out from the set, clear and toggle arithmetic, and the exact cycle of the hardware gate is checked edge by edge.

// File: rtl/softgate_pkg.sv
package softgate_pkg;
  localparam int DATA_W   = 32;
  localparam int SFT_BIT  = 31;
  localparam int GATE_BIT = 30;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TOG  = 2'd3
  } wrOp_e;

  // bits[1] = soft-reset field, bits[0] = clock-gate field
  typedef struct packed {
    logic       wrEn;
    wrOp_e      op;
    logic [1:0] bits;
    logic       hwGate;
  } ctrlStrobe_t;
endpackage

// File: rtl/softgate_ctrl.sv
module softgate_ctrl
  import softgate_pkg::*;
#(
  parameter int GATE_DELAY = 4,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              sftRst,
  output ctrlStrobe_t       strobe
);
  localparam int CNT_W = $clog2(GATE_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(GATE_DELAY);
  localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(GATE_DELAY - 1);

  logic [CNT_W-1:0] delayCnt;
  logic             inWindow;

  // Offsets above 0xF fall outside the register window.
  assign inWindow = ((busAddr >> 4) == '0);

  // Starts saturated so the reset value of soft reset does not re-trigger.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   delayCnt <= CNT_MAX;
    else if (!sftRst)            delayCnt <= '0;
    else if (delayCnt != CNT_MAX) delayCnt <= delayCnt + 1'b1;
  end

  always_comb begin
    strobe.wrEn   = busWrite && inWindow;
    strobe.op     = wrOp_e'(busAddr[3:2]);
    strobe.bits   = {busWdata[SFT_BIT], busWdata[GATE_BIT]};
    strobe.hwGate = sftRst && (delayCnt == CNT_FIRE);
  end

  // R8: hardware gate request is a single-cycle event per soft-reset rising
  assert_one_shot_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hwGate |=> !strobe.hwGate);
endmodule

// File: rtl/softgate_dp.sv
module softgate_dp
  import softgate_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  output logic              sftRst,
  output logic              clkGate,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] chanRst,
  output logic              clkEn
);
  logic [1:0] swNext;

  function automatic logic [1:0] applyOp(input logic [1:0] cur,
                                         input logic [1:0] mask,
                                         input wrOp_e op);
    case (op)
      OP_LOAD: return mask;
      OP_SET:  return cur | mask;
      OP_CLR:  return cur & ~mask;
      default: return cur ^ mask;
    endcase
  endfunction

  always_comb begin
    swNext = {sftRst, clkGate};
    if (strobe.wrEn) swNext = applyOp({sftRst, clkGate}, strobe.bits, strobe.op);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sftRst  <= 1'b1;
      clkGate <= 1'b1;
    end else begin
      sftRst  <= swNext[1];
      clkGate <= swNext[0] | strobe.hwGate;
    end
  end

  always_comb begin
    rdData           = '0;
    rdData[SFT_BIT]  = sftRst;
    rdData[GATE_BIT] = clkGate;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chanRst
    assign chanRst[ch] = sftRst;
  end
  assign clkEn = ~clkGate;

  // R4: set alias raises the soft-reset bit
  assert_set_sft_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.op == OP_SET && strobe.bits[1]) |=> sftRst);
  // R5: clear alias drops the gate bit when hardware is not setting it
  assert_clr_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.op == OP_CLR && strobe.bits[0] && !strobe.hwGate) |=> !clkGate);
  // R10: hardware gate request always lands
  assert_hw_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hwGate |=> clkGate);
  // R12: no write and no hardware event keeps the register still
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wrEn && !strobe.hwGate) |=> $stable({sftRst, clkGate}));
endmodule

// File: rtl/softgate_top.sv
module softgate_top
  import softgate_pkg::*;
#(
  parameter int GATE_DELAY = 4,
  parameter int NUM_CH     = 4,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [NUM_CH-1:0] chanRst,
  output logic              clkEn
);
  ctrlStrobe_t strobe;
  logic        sftRst;
  logic        clkGate;

  softgate_ctrl #(.GATE_DELAY(GATE_DELAY), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .sftRst(sftRst), .strobe(strobe)
  );

  softgate_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sftRst(sftRst),
    .clkGate(clkGate), .rdData(busRdata), .chanRst(chanRst), .clkEn(clkEn)
  );
endmodule

// File: tb/sim_softgate_top.sv
`timescale 1ns/1ps
module sim_softgate_top;
  localparam int DLY = 4;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NCH-1:0] chanRst;
  logic        clkEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  softgate_top #(.GATE_DELAY(DLY), .NUM_CH(NCH), .ADDR_W(4)) u0 (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .chanRst(chanRst), .clkEn(clkEn)
  );

  function automatic logic [31:0] word(input logic s, input logic g);
    return {s, g, 30'b0};
  endfunction

  // Called at a negedge; returns at the next negedge with the write taken.
  task automatic busWr(input logic [3:0] off, input logic [31:0] data);
    busWrite = 1'b1; busAddr = off; busWdata = data;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic chk(input string tag, input logic s, input logic g);
    checks++;
    if (busRdata !== word(s, g)) begin
      errors++;
      $display("FAIL %s: rdata=%h expected=%h", tag, busRdata, word(s, g));
    end
    checks++;
    if (chanRst !== {NCH{s}} || clkEn !== ~g) begin
      errors++;
      $display("FAIL R11 (%s): chanRst=%b clkEn=%b expected chanRst=%b clkEn=%b",
               tag, chanRst, clkEn, {NCH{s}}, ~g);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [1:0] st, msk, ex;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 power-on", 1'b1, 1'b1);
    for (int o = 0; o < 4; o++) begin
      busAddr = 4'(o * 4);
      #1;
      chk("R2 read at every offset", 1'b1, 1'b1);
    end
    @(negedge clk);
    repeat (2 * DLY) @(negedge clk);
    chk("R1 no gate event from reset state", 1'b1, 1'b1);

    // R12: bus activity without the write strobe
    busAddr = 4'h8; busWdata = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R12 no write strobe", 1'b1, 1'b1);

    // R3..R6 exhaustive sweep: state x mask x op
    for (int s = 0; s < 4; s++) begin
      for (int op = 0; op < 4; op++) begin
        for (int w = 0; w < 4; w++) begin
          st = 2'(s); msk = 2'(w);
          busWr(4'h0, 32'h0);
          busWr(4'h0, word(st[1], st[0]));
          busWr(4'(op * 4), word(msk[1], msk[0]) | 32'h0000_5A5A);
          case (op)
            0: ex = msk;
            1: ex = st | msk;
            2: ex = st & ~msk;
            default: ex = st ^ msk;
          endcase
          case (op)
            0: chk("R3 load", ex[1], ex[0]);
            1: chk("R4 set", ex[1], ex[0]);
            2: chk("R5 clear", ex[1], ex[0]);
            default: chk("R6 toggle", ex[1], ex[0]);
          endcase
        end
      end
    end

    // R7: gate flag exactly DLY edges after soft-reset rising
    busWr(4'h0, 32'h0);
    repeat (DLY + 2) @(negedge clk);
    busWr(4'h4, word(1'b1, 1'b0));
    chk("R7 edge t", 1'b1, 1'b0);
    for (int k = 1; k <= DLY; k++) begin
      @(negedge clk);
      chk("R7 edge count", 1'b1, k == DLY);
    end

    // R8: software clear holds while soft reset stays high
    busWr(4'h8, word(1'b0, 1'b1));
    repeat (3 * DLY) @(negedge clk);
    chk("R8 clear holds", 1'b1, 1'b0);
    busWr(4'h4, word(1'b1, 1'b0));
    repeat (3 * DLY) @(negedge clk);
    chk("R8 re-set no retrigger", 1'b1, 1'b0);

    // R9: early release aborts, next rising restarts full delay
    busWr(4'h0, 32'h0);
    busWr(4'h4, word(1'b1, 1'b0));
    repeat (DLY - 2) @(negedge clk);
    busWr(4'h8, word(1'b1, 1'b0));
    repeat (3 * DLY) @(negedge clk);
    chk("R9 aborted", 1'b0, 1'b0);
    busWr(4'h4, word(1'b1, 1'b0));
    for (int k = 1; k <= DLY; k++) begin
      @(negedge clk);
      chk("R9 restart count", 1'b1, k == DLY);
    end

    // R10: hardware set collides with software clear, then with toggle
    for (int op = 2; op < 4; op++) begin
      busWr(4'h0, 32'h0);
      busWr(4'h4, word(1'b1, 1'b0));
      repeat (DLY - 1) @(negedge clk);
      busWr(4'(op * 4), word(1'b0, 1'b1));
      chk(op == 2 ? "R10 hw vs clear" : "R10 hw vs toggle", 1'b1, 1'b1);
    end

    // Release sequence: drop reset, then ungate
    busWr(4'h8, word(1'b1, 1'b0));
    chk("R5 release reset", 1'b0, 1'b1);
    busWr(4'h8, word(1'b0, 1'b1));
    chk("R5 ungate", 1'b0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule